// File: doc/BRIEF.md
# One-Time-Programmable Wiper Position Controller

This block keeps the 8-bit tap position for a 256-step digitally controlled resistor. It also runs the single permanent-programming attempt that sets the position used at power-up. Code 0x00 selects the tap at the B end of the ladder.

It sits behind a bus decoder that has already parsed each command. That decoder presents a data byte, a program flag and a status read request. The block drives the tap select to the ladder decoder. It also drives a burn strobe and a burn value to the fuse array, and it reads the stored fuse value back.

When the block leaves power-on reset, it chooses the starting tap. If the fuse array reports that it was never burned, the tap is midscale. If the array was burned, the tap is the stored fuse value.

A write with the program flag set starts the one allowed attempt, which burns the current tap value. After a fixed strobe and a settle time, the block compares the fuse read-back with the value it burned. It records the result in two status bits.

Top module: `otpw_wiper_ctrl`

## Requirements
- R1: On leaving reset with the fuse array unburned (`fuse_blown`=0), `tap_sel` is 0x80 from the first cycle after reset release, and a status read returns `rd_stat`=2'b00.
- R2: On leaving reset with `fuse_blown`=1, `tap_sel` takes the value of `fuse_q` one cycle after reset release, and a status read returns 2'b11.
- R3: A write with `wr_prog`=0 while `busy`=0 loads `wr_data` into `tap_sel` on the next clock edge. This holds for codes 0x00 and 0xFF as well.
- R4: A write with `wr_prog`=1, made while idle and before any attempt, raises `fuse_burn` for exactly 16 consecutive cycles starting in the cycle after the write. During that strobe `fuse_d` equals the tap value held when the write arrived, and the write's data byte leaves `tap_sel` unchanged.
- R5: `busy` is high for 20 cycles after an accepted program write (16 burn + 4 settle). Any write that arrives while `busy`=1 is ignored and leaves `tap_sel` unchanged.
- R6: Status bit 1 (E1) is set by the edge that accepts the program write. On the last settle edge, bit 0 (E0) is set only if `fuse_q` equals `fuse_d`. The encoding is 00 = never programmed, 10 = attempted but verify failed, 11 = programmed and verified.
- R7: After an attempt, or after power-up with `fuse_blown`=1, a write with `wr_prog`=1 raises no `fuse_burn`, changes neither `tap_sel` nor the status, and leaves `busy` low.
- R8: After programming, writes with `wr_prog`=0 still change `tap_sel`. The burned value is restored only at the next reset release.
- R9: A `rd_req` produces `rd_ack` on the next cycle, with `rd_stat` holding the status as it was before the clock edge that sampled the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_valid | input | 1 | Decoded write command valid for one cycle |
| wr_prog | input | 1 | Program flag of the write (1 = burn current tap) |
| wr_data | input | 8 | Tap code carried by the write |
| rd_req | input | 1 | Status read-back request |
| tap_sel | output | 8 | Tap select to the ladder decoder |
| busy | output | 1 | Power-up load or burn/settle sequence in progress |
| rd_ack | output | 1 | Read-back response valid |
| rd_stat | output | 2 | Status {E1,E0} returned by the read |
| fuse_burn | output | 1 | Burn strobe to the fuse array |
| fuse_d | output | 8 | Value to burn into the fuse array |
| fuse_blown | input | 1 | Fuse array reports that it has been burned |
| fuse_q | input | 8 | Stored fuse value read back |

## Verification
The status read-back and the verify compare can fall on the same clock edge. To force this, the bench raises `rd_req` so that it is sampled on the last settle edge of an attempt whose fuses burn correctly. That read must return the pre-compare code 10, and a second read right after it must return 11.

A normal write that arrives in the middle of the burn strobe also overlaps with the running sequence. The bench judges it by confirming that `tap_sel` stays at the burned value.

// File: rtl/otpw_pkg.sv
package otpw_pkg;

  typedef enum logic [1:0] {
    ST_LOAD   = 2'd0,
    ST_IDLE   = 2'd1,
    ST_BURN   = 2'd2,
    ST_SETTLE = 2'd3
  } otpw_state_e;

  localparam logic [1:0] STAT_NONE = 2'b00;
  localparam logic [1:0] STAT_FAIL = 2'b10;
  localparam logic [1:0] STAT_OK   = 2'b11;

endpackage

// File: rtl/otpw_seq.sv
module otpw_seq
  import otpw_pkg::*;
#(
  parameter int PULSE_CYC  = 16,
  parameter int SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load_ev,
  output logic burn,
  output logic check_ev,
  output logic busy
);

  localparam int MAXC = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  otpw_state_e     state;
  logic [CW-1:0]   cnt;

  always_comb begin
    load_ev  = (state == ST_LOAD);
    burn     = (state == ST_BURN);
    check_ev = (state == ST_SETTLE) && (cnt == CW'(SETTLE_CYC - 1));
    busy     = (state != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_LOAD;
      cnt   <= '0;
    end else begin
      case (state)
        ST_LOAD: state <= ST_IDLE;
        ST_IDLE: begin
          if (start) begin
            state <= ST_BURN;
            cnt   <= '0;
          end
        end
        ST_BURN: begin
          if (cnt == CW'(PULSE_CYC - 1)) begin
            state <= ST_SETTLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SETTLE: begin
          if (check_ev) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/otpw_tapreg.sv
module otpw_tapreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_ev,
  input  logic         fuse_blown,
  input  logic [W-1:0] fuse_q,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] tap
);

  localparam logic [W-1:0] MIDSCALE = W'(1) << (W - 1);

  function automatic logic [W-1:0] power_on_code(input logic blown,
                                                 input logic [W-1:0] stored);
    return blown ? stored : MIDSCALE;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap <= MIDSCALE;
    end else if (load_ev) begin
      tap <= power_on_code(fuse_blown, fuse_q);
    end else if (wr_en) begin
      tap <= wr_data;
    end
  end

endmodule

// File: rtl/otpw_status.sv
module otpw_status
  import otpw_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_ev,
  input  logic         fuse_blown,
  input  logic         attempt_ev,
  input  logic         check_ev,
  input  logic [W-1:0] fuse_q,
  input  logic [W-1:0] burn_val,
  input  logic         rd_req,
  output logic         attempted,
  output logic [1:0]   stat,
  output logic         rd_ack,
  output logic [1:0]   rd_stat
);

  function automatic logic verify_ok(input logic [W-1:0] readback,
                                     input logic [W-1:0] wanted);
    return (readback == wanted);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attempted <= 1'b0;
      stat      <= STAT_NONE;
    end else if (load_ev) begin
      attempted <= fuse_blown;
      stat      <= fuse_blown ? STAT_OK : STAT_NONE;
    end else if (attempt_ev) begin
      attempted <= 1'b1;
      stat      <= STAT_FAIL;
    end else if (check_ev) begin
      stat[0]   <= verify_ok(fuse_q, burn_val);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ack  <= 1'b0;
      rd_stat <= 2'b00;
    end else begin
      rd_ack  <= rd_req;
      if (rd_req) rd_stat <= stat;
    end
  end

endmodule

// File: rtl/otpw_wiper_ctrl.sv
module otpw_wiper_ctrl #(
  parameter int W          = 8,
  parameter int PULSE_CYC  = 16,
  parameter int SETTLE_CYC = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  input  logic         wr_prog,
  input  logic [W-1:0] wr_data,
  input  logic         rd_req,
  output logic [W-1:0] tap_sel,
  output logic         busy,
  output logic         rd_ack,
  output logic [1:0]   rd_stat,
  output logic         fuse_burn,
  output logic [W-1:0] fuse_d,
  input  logic         fuse_blown,
  input  logic [W-1:0] fuse_q
);

  logic       load_ev;
  logic       check_ev;
  logic       busy_w;
  logic       attempted_q;
  logic [1:0] stat_w;
  logic       wr_accept;
  logic       norm_wr;
  logic       prog_req;

  assign wr_accept = wr_valid && !busy_w;
  assign norm_wr   = wr_accept && !wr_prog;
  assign prog_req  = wr_accept && wr_prog && !attempted_q;
  assign busy      = busy_w;

  otpw_seq #(.PULSE_CYC(PULSE_CYC), .SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (prog_req),
    .load_ev  (load_ev),
    .burn     (fuse_burn),
    .check_ev (check_ev),
    .busy     (busy_w)
  );

  otpw_tapreg #(.W(W)) u_tap (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_ev    (load_ev),
    .fuse_blown (fuse_blown),
    .fuse_q     (fuse_q),
    .wr_en      (norm_wr),
    .wr_data    (wr_data),
    .tap        (tap_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fuse_d <= '0;
    else if (prog_req) fuse_d <= tap_sel;
  end

  otpw_status #(.W(W)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_ev    (load_ev),
    .fuse_blown (fuse_blown),
    .attempt_ev (prog_req),
    .check_ev   (check_ev),
    .fuse_q     (fuse_q),
    .burn_val   (fuse_d),
    .rd_req     (rd_req),
    .attempted  (attempted_q),
    .stat       (stat_w),
    .rd_ack     (rd_ack),
    .rd_stat    (rd_stat)
  );

endmodule

// File: rtl/otpw_chk.sv
module otpw_chk #(
  parameter int W         = 8,
  parameter int PULSE_CYC = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         fuse_burn,
  input logic [W-1:0] fuse_d,
  input logic [W-1:0] tap_sel,
  input logic [W-1:0] fuse_q,
  input logic         fuse_blown,
  input logic         load_ev,
  input logic         check_ev,
  input logic         rd_req,
  input logic         rd_ack,
  input logic [1:0]   stat_w
);

  localparam int RW = $clog2(PULSE_CYC + 2);

  logic [RW-1:0] run;
  logic          seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= '0;
      seen <= 1'b0;
    end else begin
      run <= fuse_burn ? run + 1'b1 : '0;
      if (fuse_burn) seen <= 1'b1;
    end
  end

  a_r4_burn_not_long: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_burn |-> (run < RW'(PULSE_CYC)));

  a_r4_burn_full_len: assert property (@(posedge clk) disable iff (!rst_n)
    (!fuse_burn && run != '0) |-> (run == RW'(PULSE_CYC)));

  a_r4_burn_value: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fuse_burn) |-> (fuse_d == tap_sel));

  a_r5_tap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_burn && $past(fuse_burn)) |-> $stable(tap_sel));

  a_r7_single_burn: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fuse_burn) |-> !seen);

  a_r2_fuse_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && fuse_blown) |=> (tap_sel == $past(fuse_q)));

  a_r6_e1_after_check: assert property (@(posedge clk) disable iff (!rst_n)
    check_ev |=> stat_w[1]);

  a_r9_ack: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_ack);

endmodule

bind otpw_wiper_ctrl otpw_chk #(.W(W), .PULSE_CYC(PULSE_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fuse_burn  (fuse_burn),
  .fuse_d     (fuse_d),
  .tap_sel    (tap_sel),
  .fuse_q     (fuse_q),
  .fuse_blown (fuse_blown),
  .load_ev    (load_ev),
  .check_ev   (check_ev),
  .rd_req     (rd_req),
  .rd_ack     (rd_ack),
  .stat_w     (stat_w)
);

// File: tb/sim_otpw_wiper_ctrl.sv
`timescale 1ns/1ps
module sim_otpw_wiper_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_valid, wr_prog, rd_req;
  logic [7:0] wr_data;
  logic [7:0] tap_sel, fuse_d, fuse_q;
  logic       busy, rd_ack, fuse_burn, fuse_blown;
  logic [1:0] rd_stat;

  logic       fm_blown;
  logic [7:0] fm_val;
  logic       fm_fault;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  otpw_wiper_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_prog(wr_prog),
    .wr_data(wr_data), .rd_req(rd_req), .tap_sel(tap_sel), .busy(busy),
    .rd_ack(rd_ack), .rd_stat(rd_stat), .fuse_burn(fuse_burn),
    .fuse_d(fuse_d), .fuse_blown(fuse_blown), .fuse_q(fuse_q)
  );

  // behavioural fuse array: first strobe cycle burns, fault flips bit 0
  assign fuse_blown = fm_blown;
  assign fuse_q     = fm_val;
  always @(posedge clk) begin
    if (fuse_burn && !fm_blown) begin
      fm_blown <= 1'b1;
      fm_val   <= fuse_d ^ {7'b0, fm_fault};
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_ack) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected ack", 1, 0);
      end else begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rd_stat == e, t, rd_stat, e);
      end
    end
  end

  task automatic power_on();
    rst_n = 1'b0; wr_valid = 1'b0; wr_prog = 1'b0; rd_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic write(input logic [7:0] d, input logic p);
    wr_data = d; wr_prog = p; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; wr_prog = 1'b0;
  endtask

  task automatic read(input logic [1:0] e, input string t);
    rd_req = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic attempt(input logic [7:0] byte_in, input logic [7:0] exp_val);
    int burn_n = 0;
    int busy_n = 0;
    write(byte_in, 1'b1);
    for (int i = 0; i < 20; i++) begin
      if (fuse_burn) burn_n++;
      if (busy) busy_n++;
      if (i == 0) begin
        chk(fuse_d == exp_val, "R4 burn value", fuse_d, exp_val);
        chk(tap_sel == exp_val, "R4 data byte ignored", tap_sel, exp_val);
      end
      if (i == 5) begin wr_data = 8'h33; wr_prog = 1'b0; wr_valid = 1'b1; end
      if (i == 6) wr_valid = 1'b0;
      if (i == 8) begin rd_req = 1'b1; exp_q.push_back(2'b10); tag_q.push_back("R6 E1 on attempt"); end
      if (i == 9) begin
        rd_req = 1'b0;
        chk(tap_sel == exp_val, "R5 write while busy", tap_sel, exp_val);
      end
      if (i == 19) begin rd_req = 1'b1; exp_q.push_back(2'b10); tag_q.push_back("R9 read on compare edge"); end
      @(negedge clk);
    end
    rd_req = 1'b0;
    chk(burn_n == 16, "R4 burn length", burn_n, 16);
    chk(busy_n == 20, "R5 busy length", busy_n, 20);
    chk(busy == 1'b0, "R5 idle after settle", busy, 0);
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_prog = 1'b0; rd_req = 1'b0; wr_data = 8'h00;
    fm_blown = 1'b0; fm_val = 8'h00; fm_fault = 1'b1;

    // device A: faulty fuses
    power_on();
    chk(tap_sel == 8'h80, "R1 midscale", tap_sel, 8'h80);
    chk(busy == 1'b0, "R1 idle", busy, 0);
    read(2'b00, "R1 status");
    write(8'h12, 1'b0); chk(tap_sel == 8'h12, "R3 write", tap_sel, 8'h12);
    write(8'hFF, 1'b0); chk(tap_sel == 8'hFF, "R3 top code", tap_sel, 8'hFF);
    write(8'h00, 1'b0); chk(tap_sel == 8'h00, "R3 B-end code", tap_sel, 8'h00);
    write(8'h5A, 1'b0);
    attempt(8'hA7, 8'h5A);
    read(2'b10, "R6 verify fail");
    write(8'hA7, 1'b1);
    for (int k = 0; k < 3; k++) begin
      chk(fuse_burn == 1'b0, "R7 no second burn", fuse_burn, 0);
      chk(busy == 1'b0, "R7 stays idle", busy, 0);
      @(negedge clk);
    end
    chk(tap_sel == 8'h5A, "R7 tap unchanged", tap_sel, 8'h5A);
    read(2'b10, "R7 status unchanged");

    power_on();
    chk(tap_sel == 8'h5B, "R2 fuse load", tap_sel, 8'h5B);
    read(2'b11, "R2 status");
    write(8'h20, 1'b1);
    chk(fuse_burn == 1'b0, "R7 after power-up", fuse_burn, 0);
    chk(tap_sel == 8'h5B, "R7 tap after power-up", tap_sel, 8'h5B);
    write(8'h20, 1'b0); chk(tap_sel == 8'h20, "R8 volatile write", tap_sel, 8'h20);
    power_on();
    chk(tap_sel == 8'h5B, "R8 restore on power-up", tap_sel, 8'h5B);

    // device B: good fuses
    fm_blown = 1'b0; fm_val = 8'h00; fm_fault = 1'b0;
    power_on();
    chk(tap_sel == 8'h80, "R1 fresh device", tap_sel, 8'h80);
    write(8'hC3, 1'b0);
    attempt(8'h00, 8'hC3);
    read(2'b11, "R6 verify pass");
    power_on();
    chk(tap_sel == 8'hC3, "R2 burned value", tap_sel, 8'hC3);
    read(2'b11, "R2 status after burn");

    chk(exp_q.size() == 0, "R9 all reads answered", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule